// File: doc/BRIEF.md
# Flash Bus Arbiter with Automatic Suspend

This block shares one serial flash bus between two requesters. The first is a cache-side read port that needs low latency. The second is a command port that runs reads, sector erases, page programs and status-register writes. When no operation is running, the cache port wins any tie. A cache request that arrives during a short command-port read waits until the read is finished. A cache request that arrives during a long erase, program or status write causes the arbiter to suspend that operation instead.

To suspend, the arbiter issues a suspend opcode toward the bus shifter at a byte boundary. It then waits until the flash reports that it is suspended, and grants the bus to the cache port. The cache port holds the bus for a retriggerable lock window. Each cache transaction that starts inside the window restarts it. When the window runs out, the arbiter issues a resume opcode and hands the bus back to the command port.

The arbiter counts suspends per command operation. It raises a sticky starvation flag if a new suspend is requested before the resume preparation interval has elapsed.

Top module: `fbus_susp_arb`

## Requirements
- R1: After reset, `cache_gnt`, `cmd_gnt`, `issue_valid` and `starve` are 0, and `sus_count` is 0.
- R2: With the bus idle, a request on `cache_req` is granted on the next clock edge, and it wins over a simultaneous `cmd_req`. The two grants are never high together.
- R3: If the granted command operation is a read (`cmd_kind` = 2'b00), a cache request does not cause a suspend. `cmd_gnt` stays high until `cmd_done`, and the cache port is granted only after the bus has returned to idle.
- R4: If the granted operation is long (`cmd_kind` 2'b01 sector erase, 2'b10 page program, 2'b11 status write), a cache request drops `cmd_gnt` and raises `issue_valid` with `issue_byte` = 8'h75.
- R5: While `byte_busy` is high, no suspend is issued and `cmd_gnt` stays high. The suspend is issued on the edge after `byte_busy` falls.
- R6: After the suspend byte is accepted, `cache_gnt` stays low until `status_sus` (bit 15 of the 16-bit status word, which is bit 7 of status register 2) reads 1. The grant follows on the next edge.
- R7: Once granted after a suspend, the cache port keeps `cache_gnt` for LOCK_CYC+1 clock edges after `cache_req` falls. A `cache_req` that rises inside this window restarts the window.
- R8: When the window expires, `issue_valid` rises with `issue_byte` = 8'h7A. Once that byte is accepted, `cmd_gnt` returns on the next edge.
- R9: `sus_count` rises by one for each suspend of the current command operation. It is 0 once a new command operation has been granted.
- R10: A suspend requested fewer than PREP_CYC cycles after `cmd_gnt` returns from a resume sets `starve`. `starve` stays set until a new command operation is granted, which clears it. A suspend requested after the interval leaves `starve` at 0.
- R11: While `issue_valid` is high and `issue_ready` is low, `issue_valid` and `issue_byte` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cache_req | input | 1 | Cache port request; held high for the length of a transaction |
| cache_gnt | output | 1 | Bus granted to cache port |
| cmd_req | input | 1 | Command port request |
| cmd_kind | input | 2 | Operation type: 00 read, 01 sector erase, 10 page program, 11 status write |
| cmd_done | input | 1 | Pulse: command operation finished |
| byte_busy | input | 1 | Command port is in the middle of a byte transfer |
| cmd_gnt | output | 1 | Bus granted to command port |
| issue_valid | output | 1 | Arbiter-generated opcode waiting to go out |
| issue_byte | output | 8 | Opcode: 8'h75 suspend, 8'h7A resume |
| issue_ready | input | 1 | Shifter accepts `issue_byte` |
| status_sus | input | 1 | Suspend-status bit from the flash |
| sus_count | output | SUS_CNT_W | Suspends in the current command operation (saturating) |
| starve | output | 1 | Sticky: suspend requested inside the resume preparation interval |

## Verification
The bench probes the edges of the suspend path:
- It holds `byte_busy` high while a cache request is pending. A design that ignores it would break a byte with a suspend opcode.
- It holds `status_sus` low after the suspend byte. A premature grant would let the cache read a flash that is still busy.
- It stalls `issue_ready`. A design that moved on early would lose or change the opcode.

It also measures the lock window to the exact edge, both plain and retriggered, so that an off-by-one in the countdown or a missing reload shows up as an early resume. The starvation flag is checked both ways, with a suspend right after a resume and with one after the interval. A read operation must never be suspended, and the tie rule must favour the cache port.

// File: rtl/fbarb_pkg.sv
package fbarb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CACHE,
    ST_CMD,
    ST_SUS_TX,
    ST_SUS_WAIT,
    ST_LOCK,
    ST_RES_TX
  } arb_st_e;

  typedef enum logic [1:0] {
    OP_READ   = 2'b00,
    OP_ERASE  = 2'b01,
    OP_PROG   = 2'b10,
    OP_WRSTAT = 2'b11
  } op_kind_e;

  localparam logic [7:0] OPC_SUSPEND = 8'h75;
  localparam logic [7:0] OPC_RESUME  = 8'h7A;

  function automatic logic op_is_long(op_kind_e k);
    return k != OP_READ;
  endfunction

endpackage

// File: rtl/fbarb_countdown.sv
module fbarb_countdown #(
  parameter int unsigned LOAD_VAL = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic load,
  input  logic en,
  output logic zero
);
  localparam int W = (LOAD_VAL < 1) ? 1 : $clog2(LOAD_VAL + 1);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)                       cnt_d = '0;
    else if (load)                 cnt_d = W'(LOAD_VAL);
    else if (en && cnt_q != '0)    cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/fbarb_sus_track.sv
module fbarb_sus_track #(
  parameter int SUS_CNT_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 op_start,
  input  logic                 sus_fire,
  input  logic                 prep_busy,
  output logic [SUS_CNT_W-1:0] sus_count,
  output logic                 starve
);
  localparam logic [SUS_CNT_W-1:0] CNT_MAX = '1;

  logic [SUS_CNT_W-1:0] cnt_d;
  logic                 stv_d;
  logic                 cnt_en;

  assign cnt_en = op_start | sus_fire;

  always_comb begin
    cnt_d = sus_count;
    stv_d = starve;
    if (op_start) begin
      cnt_d = '0;
      stv_d = 1'b0;
    end else if (sus_fire) begin
      if (sus_count != CNT_MAX) cnt_d = sus_count + 1'b1;
      if (prep_busy)            stv_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sus_count <= '0;
      starve    <= 1'b0;
    end else if (cnt_en) begin
      sus_count <= cnt_d;
      starve    <= stv_d;
    end
  end

  // R10: flag is sticky within an operation
  p_starve_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    starve && !op_start |=> starve);

  // R9: a new operation starts with clean bookkeeping
  p_op_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |=> (sus_count == '0) && !starve);

endmodule

// File: rtl/fbus_susp_arb.sv
module fbus_susp_arb
  import fbarb_pkg::*;
#(
  parameter int unsigned LOCK_CYC  = 64,
  parameter int unsigned PREP_CYC  = 3200,
  parameter int          SUS_CNT_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cache_req,
  output logic                 cache_gnt,
  input  logic                 cmd_req,
  input  logic [1:0]           cmd_kind,
  input  logic                 cmd_done,
  input  logic                 byte_busy,
  output logic                 cmd_gnt,
  output logic                 issue_valid,
  output logic [7:0]           issue_byte,
  input  logic                 issue_ready,
  input  logic                 status_sus,
  output logic [SUS_CNT_W-1:0] sus_count,
  output logic                 starve
);

  arb_st_e  st_q, st_d;
  op_kind_e kind_q;
  logic     op_start;
  logic     go_sus;
  logic     lock_zero, prep_zero;
  logic     lock_load, prep_load, prep_clr;

  assign go_sus = (st_q == ST_CMD) && cache_req && op_is_long(kind_q)
                  && !byte_busy && !cmd_done;

  // next-state logic
  always_comb begin
    st_d     = st_q;
    op_start = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (cache_req)    st_d = ST_CACHE;
        else if (cmd_req) begin
          st_d     = ST_CMD;
          op_start = 1'b1;
        end
      end
      ST_CACHE:    if (!cache_req)  st_d = ST_IDLE;
      ST_CMD: begin
        if (cmd_done)     st_d = ST_IDLE;
        else if (go_sus)  st_d = ST_SUS_TX;
      end
      ST_SUS_TX:   if (issue_ready) st_d = ST_SUS_WAIT;
      ST_SUS_WAIT: if (status_sus)  st_d = ST_LOCK;
      ST_LOCK:     if (!cache_req && lock_zero) st_d = ST_RES_TX;
      ST_RES_TX:   if (issue_ready) st_d = ST_CMD;
      default:     st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        kind_q <= OP_READ;
    else if (op_start) kind_q <= op_kind_e'(cmd_kind);
  end

  // lock window: reloaded while waiting for suspend and by each cache request
  assign lock_load = (st_q == ST_SUS_WAIT) || ((st_q == ST_LOCK) && cache_req);

  fbarb_countdown #(.LOAD_VAL(LOCK_CYC)) u_lock_win (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (1'b0),
    .load  (lock_load),
    .en    (st_q == ST_LOCK),
    .zero  (lock_zero)
  );

  // resume preparation interval: loaded while the resume opcode is out
  assign prep_load = (st_q == ST_RES_TX);
  assign prep_clr  = (st_q == ST_IDLE);

  fbarb_countdown #(.LOAD_VAL(PREP_CYC)) u_prep_win (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (prep_clr),
    .load  (prep_load),
    .en    (st_q == ST_CMD),
    .zero  (prep_zero)
  );

  fbarb_sus_track #(.SUS_CNT_W(SUS_CNT_W)) u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_start  (op_start),
    .sus_fire  (go_sus),
    .prep_busy (!prep_zero),
    .sus_count (sus_count),
    .starve    (starve)
  );

  // outputs
  assign cache_gnt   = (st_q == ST_CACHE) || (st_q == ST_LOCK);
  assign cmd_gnt     = (st_q == ST_CMD);
  assign issue_valid = (st_q == ST_SUS_TX) || (st_q == ST_RES_TX);

  always_comb begin
    issue_byte = 8'h00;
    if (st_q == ST_SUS_TX)      issue_byte = OPC_SUSPEND;
    else if (st_q == ST_RES_TX) issue_byte = OPC_RESUME;
  end

  // R2: grants are mutually exclusive
  p_gnt_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(cache_gnt && cmd_gnt));

  // R4: only long operations are suspended
  p_sus_long_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SUS_TX) |-> op_is_long(kind_q));

  // R5: suspend entered only at a byte boundary
  p_no_midbyte_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SUS_TX) && ($past(st_q) == ST_CMD) |-> !$past(byte_busy));

  // R6: cache takes the bus only after the flash reports suspended
  p_sus_seen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_LOCK) && ($past(st_q) == ST_SUS_WAIT) |-> $past(status_sus));

  // R7: an active cache request keeps the locked bus
  p_lock_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_LOCK) && cache_req |=> cache_gnt);

  // R11: opcode held until accepted
  p_issue_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid && !issue_ready |=> issue_valid && $stable(issue_byte));

endmodule

// File: tb/tb_fbus_susp_arb.sv
`timescale 1ns/1ps
module tb_fbus_susp_arb;

  localparam int unsigned LOCK = 4;
  localparam int unsigned PREP = 10;
  localparam int          CW   = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cache_req, cmd_req, cmd_done, byte_busy, issue_ready, status_sus;
  logic [1:0]    cmd_kind;
  logic          cache_gnt, cmd_gnt, issue_valid, starve;
  logic [7:0]    issue_byte;
  logic [CW-1:0] sus_count;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  fbus_susp_arb #(.LOCK_CYC(LOCK), .PREP_CYC(PREP), .SUS_CNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n),
    .cache_req(cache_req), .cache_gnt(cache_gnt),
    .cmd_req(cmd_req), .cmd_kind(cmd_kind), .cmd_done(cmd_done),
    .byte_busy(byte_busy), .cmd_gnt(cmd_gnt),
    .issue_valid(issue_valid), .issue_byte(issue_byte), .issue_ready(issue_ready),
    .status_sus(status_sus), .sus_count(sus_count), .starve(starve)
  );

  task automatic nx();
    @(negedge clk);
  endtask

  task automatic chk(string rq, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", rq, act, exp, $time);
    end
  endtask

  task automatic start_op(logic [1:0] k);
    cmd_req  = 1'b1;
    cmd_kind = k;
    nx();
    chk("R2 cmd grant", int'(cmd_gnt), 1);
    chk("R9 count cleared", int'(sus_count), 0);
    chk("R10 starve cleared", int'(starve), 0);
  endtask

  task automatic end_op();
    cmd_done = 1'b1;
    cmd_req  = 1'b0;
    nx();
    cmd_done = 1'b0;
    chk("R3 idle after done", int'(cmd_gnt), 0);
  endtask

  // cache_req was just raised during a long op with byte_busy low
  task automatic do_suspend();
    nx();
    chk("R4 suspend valid", int'(issue_valid), 1);
    chk("R4 suspend byte", int'(issue_byte), 8'h75);
    chk("R4 cmd gnt dropped", int'(cmd_gnt), 0);
    nx();
    chk("R6 no grant before sus", int'(cache_gnt), 0);
    status_sus = 1'b1;
    nx();
    chk("R6 grant after sus", int'(cache_gnt), 1);
  endtask

  task automatic release_lock();
    cache_req  = 1'b0;
    status_sus = 1'b0;
    repeat (LOCK) nx();
    chk("R7 still held", int'(cache_gnt), 1);
    chk("R7 no early resume", int'(issue_valid), 0);
    nx();
    chk("R8 resume valid", int'(issue_valid), 1);
    chk("R8 resume byte", int'(issue_byte), 8'h7A);
    chk("R7 released", int'(cache_gnt), 0);
    nx();
    chk("R8 cmd regranted", int'(cmd_gnt), 1);
  endtask

  task automatic t_reset();
    chk("R1 cache_gnt", int'(cache_gnt), 0);
    chk("R1 cmd_gnt", int'(cmd_gnt), 0);
    chk("R1 issue_valid", int'(issue_valid), 0);
    chk("R1 starve", int'(starve), 0);
    chk("R1 sus_count", int'(sus_count), 0);
  endtask

  task automatic t_priority();
    cache_req = 1'b1;
    cmd_req   = 1'b1;
    cmd_kind  = 2'b01;
    nx();
    chk("R2 cache wins tie", int'(cache_gnt), 1);
    chk("R2 cmd waits", int'(cmd_gnt), 0);
    cache_req = 1'b0;
    nx();
    chk("R2 back to idle", int'(cache_gnt), 0);
    nx();
    chk("R2 cmd granted after", int'(cmd_gnt), 1);
    end_op();
  endtask

  task automatic t_short_read();
    start_op(2'b00);
    cache_req = 1'b1;
    for (int i = 0; i < 4; i++) begin
      nx();
      chk("R3 read not suspended", int'(issue_valid), 0);
      chk("R3 cmd keeps bus", int'(cmd_gnt), 1);
      chk("R3 cache waits", int'(cache_gnt), 0);
    end
    end_op();
    chk("R3 idle cycle", int'(cache_gnt), 0);
    nx();
    chk("R3 cache granted", int'(cache_gnt), 1);
    cache_req = 1'b0;
    nx();
  endtask

  task automatic t_long_kinds();
    for (int k = 1; k < 4; k++) begin
      start_op(2'(k));
      cache_req = 1'b1;
      do_suspend();
      chk("R9 one suspend", int'(sus_count), 1);
      release_lock();
      end_op();
    end
  endtask

  task automatic t_midbyte();
    start_op(2'b01);
    byte_busy = 1'b1;
    cache_req = 1'b1;
    for (int i = 0; i < 3; i++) begin
      nx();
      chk("R5 no suspend mid-byte", int'(issue_valid), 0);
      chk("R5 cmd keeps bus", int'(cmd_gnt), 1);
    end
    byte_busy = 1'b0;
    do_suspend();
    release_lock();
    end_op();
  endtask

  task automatic t_sus_wait();
    start_op(2'b10);
    cache_req = 1'b1;
    nx();
    chk("R4 suspend byte", int'(issue_byte), 8'h75);
    for (int i = 0; i < 3; i++) begin
      nx();
      chk("R6 held off while busy", int'(cache_gnt), 0);
    end
    status_sus = 1'b1;
    nx();
    chk("R6 granted once suspended", int'(cache_gnt), 1);
    release_lock();
    end_op();
  endtask

  task automatic t_ready_hold();
    start_op(2'b10);
    issue_ready = 1'b0;
    cache_req   = 1'b1;
    nx();
    chk("R11 valid", int'(issue_valid), 1);
    for (int i = 0; i < 3; i++) begin
      nx();
      chk("R11 held valid", int'(issue_valid), 1);
      chk("R11 held byte", int'(issue_byte), 8'h75);
    end
    issue_ready = 1'b1;
    nx();
    chk("R11 taken", int'(issue_valid), 0);
    status_sus = 1'b1;
    nx();
    chk("R6 grant", int'(cache_gnt), 1);
    release_lock();
    end_op();
  endtask

  task automatic t_retrigger();
    start_op(2'b11);
    cache_req = 1'b1;
    do_suspend();
    cache_req  = 1'b0;
    status_sus = 1'b0;
    nx();
    nx();
    cache_req = 1'b1;
    nx();
    chk("R7 held in window", int'(cache_gnt), 1);
    release_lock();
    end_op();
  endtask

  task automatic t_starve();
    start_op(2'b01);
    cache_req = 1'b1;
    do_suspend();
    chk("R10 first suspend clean", int'(starve), 0);
    release_lock();
    cache_req = 1'b1;
    nx();
    chk("R4 immediate re-suspend", int'(issue_byte), 8'h75);
    chk("R10 starve set", int'(starve), 1);
    chk("R9 two suspends", int'(sus_count), 2);
    nx();
    status_sus = 1'b1;
    nx();
    release_lock();
    chk("R10 starve sticky", int'(starve), 1);
    end_op();
    start_op(2'b01);
    cache_req = 1'b1;
    do_suspend();
    release_lock();
    repeat (PREP + 2) nx();
    cache_req = 1'b1;
    nx();
    chk("R10 spaced suspend no starve", int'(starve), 0);
    chk("R9 second suspend counted", int'(sus_count), 2);
    nx();
    status_sus = 1'b1;
    nx();
    release_lock();
    end_op();
  endtask

  initial begin
    rst_n = 1'b0;
    cache_req = 1'b0; cmd_req = 1'b0; cmd_done = 1'b0; byte_busy = 1'b0;
    issue_ready = 1'b1; status_sus = 1'b0; cmd_kind = 2'b00;
    repeat (3) nx();
    rst_n = 1'b1;
    nx();
    t_reset();
    t_priority();
    t_short_read();
    t_long_kinds();
    t_midbyte();
    t_sus_wait();
    t_ready_hold();
    t_retrigger();
    t_starve();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule